// File: doc/BRIEF.md
# Serial Channel with Selectable External Bit Clocks

A single full-duplex asynchronous serial channel. The host pushes bytes into an 8-deep transmit queue and pulls bytes from an 8-deep receive queue through a plain parallel strobe interface. Characters go out on `txd` and come in on `rxd`, always as one start bit (space, low), eight data bits with the least significant bit first, and one stop bit (mark, high). No parity is used.

Each direction picks its own bit clock. In internal mode it runs from a 16x oversampling strobe `tick16` that the surrounding logic supplies. In external mode it follows a 1x clock pin: the transmitter launches each bit after a falling edge of `tx_clk_ext`, and the receiver samples `rxd` on a rising edge of `rx_clk_ext`. Both external clocks are synchronised into `clk`. A loopback mode sends the transmit shifter into the receiver and holds `txd` at mark. Separate enables and flush strobes control the two directions, and a six-bit status word reports queue occupancy and receive errors.

Top module: `uart_xclk_chan`

## Requirements
- R1: After reset `txd` is 1 and `stat` is 6'b001100 (no receive data, receive queue not full, transmit queue has room, transmitter empty, no overrun, no framing error).
- R2: A transmitted character is a 0 start bit, 8 data bits LSB first and a 1 stop bit. In internal mode each bit lasts exactly 16 `tick16` strobes.
- R3: The transmit queue holds 8 bytes. With 8 stored, `stat[2]` (room available) is 0 and a further write is dropped. The stored bytes are sent in write order.
- R4: `txd` is 1 whenever `tx_on` is 0, the transmitter has nothing to send, or `loop_en` is 1.
- R5: With `tx_use_ext`=1, a frame's start bit begins only after a falling edge of `tx_clk_ext`, and each later bit changes after the next falling edge, so `txd` is stable across every rising edge.
- R6: In internal receive mode a low on the line is taken as a start bit only if the line is still low on the 8th `tick16` strobe, counting the strobe that first saw it low. A shorter low pulse produces no character.
- R7: With `rx_use_ext`=1 the receiver samples the line on each rising edge of `rx_clk_ext`.
- R8: The receive queue holds 8 bytes and `stat[1]` is 1 when it is full. A character that completes while it is full is discarded and sets the sticky overrun flag `stat[4]`. Reads do not clear that flag.
- R9: A stop bit sampled as 0 sets the sticky framing-error flag `stat[5]`, and the character is still stored.
- R10: With `loop_en`=1 the receiver takes its input from the transmit shifter and ignores `rxd`, while `txd` stays at 1.
- R11: A `tx_flush` pulse empties the transmit queue and ends any character in flight. An `rx_flush` pulse empties the receive queue and clears `stat[4]` and `stat[5]`.
- R12: `rd_byte` shows the oldest received byte, `stat[0]` is 1 while the receive queue holds data, and an `rd_stb` pulse removes that byte. `stat[3]` is 1 only when the transmit queue and the shifter are both empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | 16x oversampling strobe, one cycle wide |
| tx_clk_ext | input | 1 | External 1x transmit clock |
| rx_clk_ext | input | 1 | External 1x receive clock |
| tx_on | input | 1 | Transmitter enable |
| rx_on | input | 1 | Receiver enable |
| tx_use_ext | input | 1 | Transmitter uses `tx_clk_ext` |
| rx_use_ext | input | 1 | Receiver uses `rx_clk_ext` |
| loop_en | input | 1 | Local loopback |
| tx_flush | input | 1 | Clear transmit queue and shifter |
| rx_flush | input | 1 | Clear receive queue and error flags |
| wr_stb | input | 1 | Write `wr_byte` into transmit queue |
| wr_byte | input | 8 | Byte to transmit |
| rd_stb | input | 1 | Remove head of receive queue |
| rd_byte | output | 8 | Head of receive queue |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| stat | output | 6 | {frame err, overrun, tx empty, tx room, rx full, rx ready} |

## Verification
A queue pointer or count that goes wrong shows up at the ports within one character time, as a byte out of order, a duplicated byte or a missing byte, or within one cycle as a wrong occupancy bit in `stat`. A transmit shifter that loses its bit position gives a frame whose stop bit, sampled mid-bit by the bench, is not mark. If it fails to return to idle, `txd` stays low or `stat[3]` never rises. A receive state machine stuck outside idle or misaligned shows up as a missing byte or a false framing error at the next character, and an edge-selection error in external mode shows up as a shifted byte.

// File: rtl/uart_xc_pkg.sv
package uart_xc_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam int ST_RX_RDY  = 0;
  localparam int ST_RX_FULL = 1;
  localparam int ST_TX_ROOM = 2;
  localparam int ST_TX_EMT  = 3;
  localparam int ST_OVR     = 4;
  localparam int ST_FE      = 5;
  localparam int ST_W       = 6;
endpackage

// File: rtl/uart_xc_fifo.sv
module uart_xc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/uart_xc_tx.sv
module uart_xc_tx #(
  parameter int W   = 8,
  parameter int OVS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick16,
  input  logic         xclk,
  input  logic         use_ext,
  input  logic         en,
  input  logic         flush,
  input  logic         q_empty,
  input  logic [W-1:0] q_data,
  output logic         q_pop,
  output logic         line,
  output logic         busy
);
  localparam int DW = $clog2(OVS);
  localparam int FW = W + 2;
  localparam int BW = $clog2(FW);

  logic [DW-1:0] div_q, div_d;
  logic [2:0]    xs_q, xs_d;
  logic          busy_q, busy_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [BW-1:0] nb_q, nb_d;
  logic          bit_tick, xfall, last_bit, start;

  assign xfall    = xs_q[2] & ~xs_q[1];
  assign bit_tick = use_ext ? xfall : (tick16 && div_q == DW'(OVS - 1));
  assign last_bit = (nb_q == BW'(FW - 1));
  assign start    = bit_tick && !q_empty && (!busy_q || last_bit);

  always_comb begin
    xs_d   = {xs_q[1:0], xclk};
    div_d  = div_q;
    if (tick16) div_d = (div_q == DW'(OVS - 1)) ? '0 : div_q + 1'b1;
    busy_d = busy_q;
    sh_d   = sh_q;
    nb_d   = nb_q;
    q_pop  = 1'b0;
    if (flush || !en) begin
      busy_d = 1'b0;
      sh_d   = '1;
      nb_d   = '0;
    end else if (bit_tick) begin
      if (start) begin
        q_pop  = 1'b1;
        busy_d = 1'b1;
        sh_d   = {1'b1, q_data, 1'b0};
        nb_d   = '0;
      end else if (busy_q) begin
        if (last_bit) begin
          busy_d = 1'b0;
        end else begin
          sh_d = {1'b1, sh_q[FW-1:1]};
          nb_d = nb_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      xs_q   <= 3'b000;
      busy_q <= 1'b0;
      sh_q   <= '1;
      nb_q   <= '0;
    end else begin
      div_q  <= div_d;
      xs_q   <= xs_d;
      busy_q <= busy_d;
      sh_q   <= sh_d;
      nb_q   <= nb_d;
    end
  end

  assign line = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;

  p_start_is_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (line == 1'b0));
  p_stop_is_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && last_bit) |-> (line == 1'b1));
  p_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy_q);
endmodule

// File: rtl/uart_xc_rx.sv
module uart_xc_rx
  import uart_xc_pkg::*;
#(
  parameter int W   = 8,
  parameter int OVS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick16,
  input  logic         xclk,
  input  logic         use_ext,
  input  logic         en,
  input  logic         flush,
  input  logic         rxd,
  input  logic         loop_en,
  input  logic         loop_line,
  input  logic         q_full,
  output logic         q_push,
  output logic [W-1:0] q_data,
  output logic         ovr,
  output logic         fe
);
  localparam int DW  = $clog2(OVS);
  localparam int NBW = $clog2(W);
  localparam logic [DW-1:0] MIDC = DW'(OVS / 2 - 2);

  rx_state_e      st_q, st_d;
  logic [1:0]     rs_q, rs_d;
  logic [2:0]     xs_q, xs_d;
  logic [DW-1:0]  cnt_q, cnt_d;
  logic [NBW-1:0] nb_q, nb_d;
  logic [W-1:0]   sh_q, sh_d;
  logic           ovr_q, ovr_d, fe_q, fe_d;
  logic           line, xrise, samp;

  assign line  = loop_en ? loop_line : rs_q[1];
  assign xrise = xs_q[1] & ~xs_q[2];
  assign samp  = use_ext ? xrise : (tick16 && cnt_q == DW'(OVS - 1));

  always_comb begin
    rs_d   = {rs_q[0], rxd};
    xs_d   = {xs_q[1:0], xclk};
    st_d   = st_q;
    cnt_d  = cnt_q;
    nb_d   = nb_q;
    sh_d   = sh_q;
    ovr_d  = ovr_q;
    fe_d   = fe_q;
    q_push = 1'b0;
    if (flush) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
      nb_d  = '0;
      ovr_d = 1'b0;
      fe_d  = 1'b0;
    end else if (!en) begin
      st_d = RX_IDLE;
    end else begin
      case (st_q)
        RX_IDLE: begin
          if (use_ext) begin
            if (xrise && !line) begin
              st_d = RX_DATA;
              nb_d = '0;
            end
          end else if (tick16 && !line) begin
            st_d  = RX_START;
            cnt_d = '0;
          end
        end
        RX_START: begin
          if (tick16) begin
            if (cnt_q == MIDC) begin
              cnt_d = '0;
              nb_d  = '0;
              st_d  = line ? RX_IDLE : RX_DATA;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          if (tick16 && !use_ext)
            cnt_d = (cnt_q == DW'(OVS - 1)) ? '0 : cnt_q + 1'b1;
          if (samp) begin
            if (st_q == RX_DATA) begin
              sh_d = {line, sh_q[W-1:1]};
              nb_d = nb_q + 1'b1;
              if (nb_q == NBW'(W - 1)) st_d = RX_STOP;
            end else begin
              if (!line) fe_d = 1'b1;
              if (q_full) ovr_d = 1'b1;
              else        q_push = 1'b1;
              st_d = RX_IDLE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      rs_q  <= 2'b11;
      xs_q  <= 3'b000;
      cnt_q <= '0;
      nb_q  <= '0;
      sh_q  <= '0;
      ovr_q <= 1'b0;
      fe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      rs_q  <= rs_d;
      xs_q  <= xs_d;
      cnt_q <= cnt_d;
      nb_q  <= nb_d;
      sh_q  <= sh_d;
      ovr_q <= ovr_d;
      fe_q  <= fe_d;
    end
  end

  assign q_data = sh_q;
  assign ovr    = ovr_q;
  assign fe     = fe_q;

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !flush) |=> ovr_q);
  p_fe_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && !flush) |=> fe_q);
  p_push_ends_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |=> (st_q == RX_IDLE));
endmodule

// File: rtl/uart_xclk_chan.sv
module uart_xclk_chan
  import uart_xc_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int OVS   = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick16,
  input  logic         tx_clk_ext,
  input  logic         rx_clk_ext,
  input  logic         tx_on,
  input  logic         rx_on,
  input  logic         tx_use_ext,
  input  logic         rx_use_ext,
  input  logic         loop_en,
  input  logic         tx_flush,
  input  logic         rx_flush,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_byte,
  input  logic         rd_stb,
  output logic [W-1:0] rd_byte,
  input  logic         rxd,
  output logic         txd,
  output logic [5:0]   stat
);
  logic         txq_empty, txq_full, txq_pop, txq_push;
  logic [W-1:0] txq_data;
  logic         rxq_empty, rxq_full, rxq_push, rxq_pop;
  logic [W-1:0] rxq_din;
  logic         tx_line, tx_busy, rx_ovr, rx_fe;

  assign txq_push = wr_stb && !txq_full;
  assign rxq_pop  = rd_stb && !rxq_empty;

  uart_xc_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(txq_push), .din(wr_byte), .pop(txq_pop),
    .dout(txq_data), .empty(txq_empty), .full(txq_full));

  uart_xc_tx #(.W(W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .xclk(tx_clk_ext),
    .use_ext(tx_use_ext), .en(tx_on), .flush(tx_flush),
    .q_empty(txq_empty), .q_data(txq_data), .q_pop(txq_pop),
    .line(tx_line), .busy(tx_busy));

  uart_xc_rx #(.W(W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .xclk(rx_clk_ext),
    .use_ext(rx_use_ext), .en(rx_on), .flush(rx_flush),
    .rxd(rxd), .loop_en(loop_en), .loop_line(tx_line),
    .q_full(rxq_full), .q_push(rxq_push), .q_data(rxq_din),
    .ovr(rx_ovr), .fe(rx_fe));

  uart_xc_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rxq_push), .din(rxq_din), .pop(rxq_pop),
    .dout(rd_byte), .empty(rxq_empty), .full(rxq_full));

  assign txd = loop_en ? 1'b1 : tx_line;

  always_comb begin
    stat             = '0;
    stat[ST_RX_RDY]  = !rxq_empty;
    stat[ST_RX_FULL] = rxq_full;
    stat[ST_TX_ROOM] = !txq_full;
    stat[ST_TX_EMT]  = txq_empty && !tx_busy;
    stat[ST_OVR]     = rx_ovr;
    stat[ST_FE]      = rx_fe;
  end

  p_space_only_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> (tx_on && !loop_en));
  p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && txq_full && !txq_pop && !tx_flush) |=> txq_full);
endmodule

// File: tb/sim_uart_xclk_chan.sv
`timescale 1ns/1ps
module sim_uart_xclk_chan;
  localparam int BITC = 64;

  logic clk, rst_n, tick16, xclk;
  logic tx_on, rx_on, tx_use_ext, rx_use_ext, loop_en;
  logic tx_flush, rx_flush, wr_stb, rd_stb, rxd, txd;
  logic [7:0] wr_byte, rd_byte;
  logic [5:0] stat;
  int checks, fails;
  bit finished;

  uart_xclk_chan u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16),
    .tx_clk_ext(xclk), .rx_clk_ext(xclk),
    .tx_on(tx_on), .rx_on(rx_on), .tx_use_ext(tx_use_ext),
    .rx_use_ext(rx_use_ext), .loop_en(loop_en),
    .tx_flush(tx_flush), .rx_flush(rx_flush),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_stb(rd_stb),
    .rd_byte(rd_byte), .rxd(rxd), .txd(txd), .stat(stat));

  initial begin clk = 0; forever #10 clk = ~clk; end

  initial begin
    tick16 = 0;
    forever begin
      repeat (3) @(negedge clk);
      tick16 = 1;
      @(negedge clk);
      tick16 = 0;
    end
  end

  initial begin
    xclk = 0;
    forever begin
      repeat (20) @(negedge clk);
      xclk = ~xclk;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_stb = 1; wr_byte = b;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic rd_pop();
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0;
  endtask

  task automatic wait_start(output bit seen);
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (txd == 1'b0) begin seen = 1; break; end
    end
  endtask

  // internal-mode frame capture, mid-bit sampling
  task automatic grab_int(input string req, input logic [7:0] exp);
    bit seen;
    logic [7:0] got;
    wait_start(seen);
    chk({req, " start seen"}, 32'(seen), 32'd1);
    repeat (BITC/2) @(negedge clk);
    chk({req, " start bit"}, 32'(txd), 32'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (BITC) @(negedge clk);
      got[i] = txd;
    end
    chk({req, " data"}, 32'(got), 32'(exp));
    repeat (BITC) @(negedge clk);
    chk({req, " stop bit"}, 32'(txd), 32'd1);
  endtask

  task automatic send_int(input logic [7:0] b, input bit good_stop);
    @(negedge clk); rxd = 0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = good_stop;
    if (good_stop) repeat (BITC) @(negedge clk);
    else begin repeat (40) @(negedge clk); rxd = 1; repeat (BITC) @(negedge clk); end
  endtask

  task automatic t_reset();
    chk("R1 txd", 32'(txd), 32'd1);
    chk("R1 stat", 32'(stat), 32'h0C);
  endtask

  task automatic t_tx_int();
    tx_on = 1;
    wr(8'hA5);
    grab_int("R2 frame A5", 8'hA5);
    repeat (BITC) @(negedge clk);
    chk("R4 idle mark", 32'(txd), 32'd1);
    chk("R12 tx empty", 32'(stat[3]), 32'd1);
  endtask

  task automatic t_tx_depth();
    bit low;
    tx_on = 0;
    for (int i = 0; i < 9; i++) wr(8'(i + 8'h30));
    @(negedge clk);
    chk("R3 no room", 32'(stat[2]), 32'd0);
    chk("R4 disabled mark", 32'(txd), 32'd1);
    tx_on = 1;
    for (int i = 0; i < 8; i++) grab_int("R3 order", 8'(i + 8'h30));
    low = 0;
    for (int i = 0; i < 1000; i++) begin @(negedge clk); if (!txd) low = 1; end
    chk("R3 ninth dropped", 32'(low), 32'd0);
    chk("R3 tx empty", 32'(stat[3]), 32'd1);
  endtask

  task automatic t_tx_flush();
    bit low;
    tx_on = 0;
    wr(8'h11); wr(8'h22); wr(8'h33);
    chk("R12 not empty", 32'(stat[3]), 32'd0);
    @(negedge clk); tx_flush = 1; @(negedge clk); tx_flush = 0;
    chk("R11 tx flushed", 32'(stat[3:2]), 32'd3);
    tx_on = 1;
    low = 0;
    for (int i = 0; i < 1000; i++) begin @(negedge clk); if (!txd) low = 1; end
    chk("R11 nothing sent", 32'(low), 32'd0);
  endtask

  task automatic t_tx_ext();
    bit seen;
    logic [9:0] exp, got;
    exp = {1'b1, 8'h3C, 1'b0};
    tx_use_ext = 1; tx_on = 1;
    wr(8'h3C);
    wait_start(seen);
    chk("R5 start seen", 32'(seen), 32'd1);
    chk("R5 launch in low phase", 32'(xclk), 32'd0);
    for (int i = 0; i < 10; i++) begin
      @(posedge xclk);
      repeat (2) @(negedge clk);
      got[i] = txd;
    end
    chk("R5 ext frame", 32'(got), 32'(exp));
    repeat (60) @(negedge clk);
    tx_use_ext = 0;
    chk("R5 done empty", 32'(stat[3]), 32'd1);
  endtask

  task automatic t_rx_int();
    rx_on = 1;
    send_int(8'h5A, 1);
    chk("R12 rx ready", 32'(stat[0]), 32'd1);
    chk("R2 rx byte", 32'(rd_byte), 32'h5A);
    rd_pop();
    chk("R12 rx drained", 32'(stat[0]), 32'd0);
  endtask

  task automatic t_glitch();
    @(negedge clk); rxd = 0;
    repeat (12) @(negedge clk);
    rxd = 1;
    repeat (800) @(negedge clk);
    chk("R6 glitch ignored", 32'(stat[0]), 32'd0);
    chk("R6 no error", 32'(stat[5]), 32'd0);
  endtask

  task automatic t_frame_err();
    send_int(8'h81, 0);
    repeat (100) @(negedge clk);
    chk("R9 fe set", 32'(stat[5]), 32'd1);
    chk("R9 byte kept", 32'(rd_byte), 32'h81);
    rd_pop();
    chk("R9 fe sticky", 32'(stat[5]), 32'd1);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 8; i++) send_int(8'(8'h40 + i), 1);
    chk("R8 full", 32'(stat[1]), 32'd1);
    chk("R8 no ovr yet", 32'(stat[4]), 32'd0);
    send_int(8'hEE, 1);
    chk("R8 ovr set", 32'(stat[4]), 32'd1);
    for (int i = 0; i < 8; i++) begin
      chk("R8 kept order", 32'(rd_byte), 32'(8'h40 + i));
      rd_pop();
    end
    chk("R8 drained", 32'(stat[0]), 32'd0);
    chk("R8 ovr sticky", 32'(stat[4]), 32'd1);
    @(negedge clk); rx_flush = 1; @(negedge clk); rx_flush = 0;
    chk("R11 flags cleared", 32'(stat[5:4]), 32'd0);
  endtask

  task automatic t_rx_ext();
    logic [7:0] b;
    b = 8'hC6;
    rx_use_ext = 1;
    @(negedge xclk); rxd = 0;
    for (int i = 0; i < 8; i++) begin @(negedge xclk); rxd = b[i]; end
    @(negedge xclk); rxd = 1;
    @(posedge xclk);
    repeat (6) @(negedge clk);
    chk("R7 rx ready", 32'(stat[0]), 32'd1);
    chk("R7 ext byte", 32'(rd_byte), 32'(b));
    chk("R7 no fe", 32'(stat[5]), 32'd0);
    rd_pop();
    rx_use_ext = 0;
  endtask

  task automatic t_loop();
    bit low;
    loop_en = 1; tx_on = 1; rx_on = 1;
    repeat (4) @(negedge clk);
    rxd = 0;
    wr(8'hC3);
    low = 0;
    for (int i = 0; i < 900; i++) begin @(negedge clk); if (!txd) low = 1; end
    chk("R10 txd mark", 32'(low), 32'd0);
    chk("R10 looped ready", 32'(stat[0]), 32'd1);
    chk("R10 looped byte", 32'(rd_byte), 32'hC3);
    rd_pop();
    rxd = 1;
    repeat (10) @(negedge clk);
    loop_en = 0;
  endtask

  initial begin
    checks = 0; fails = 0; finished = 0;
    rst_n = 0; tx_on = 0; rx_on = 0; tx_use_ext = 0; rx_use_ext = 0;
    loop_en = 0; tx_flush = 0; rx_flush = 0; wr_stb = 0; wr_byte = 0;
    rd_stb = 0; rxd = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_int();
    t_tx_depth();
    t_tx_flush();
    t_tx_ext();
    t_rx_int();
    t_glitch();
    t_frame_err();
    t_overrun();
    t_rx_ext();
    t_loop();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule